// File: doc/BRIEF.md
# Barrier-Aware Command Queue Dispatcher

This block is the per-queue decision unit of a command-ring front end. Each wakeup looks at the packet at the current dispatch position and settles what happens to it. The packet may be issued to a downstream executor, retired locally as a dependency barrier, or held back. When a packet is held back, the block records why. Ordering comes from two sources. A barrier flag on a packet makes it wait until every earlier dispatched packet has completed. A dependency-barrier packet waits until all of its dependency signals are satisfied.

Wakeups are not free. Each one is scheduled by an internal down-counter set to a fixed processing delay, and only one wakeup can be pending at a time. A queue blocked by a packet's barrier flag still takes one empty wakeup, which models the processing time it spent. After that it sleeps until the completion that drains the last earlier packet, and that completion reopens the queue with a one-cycle wakeup. The ring tracker supplies the in-flight count and completion events. The surrounding logic supplies the dependency status.

The issue port is a valid/ready stream. Once `disp_valid` rises it stays high with `disp_type` unchanged until a cycle with `disp_ready` high. While it waits, no further wakeup is evaluated. A due wakeup is deferred rather than lost, and it is evaluated in the cycle of the handshake.

Top module: `pq_barrier_dispatch`

## Requirements
- R1: After reset `q_state` is 0 (open), `bar_flag`, `disp_valid`, `disp_idx_inc`, `dep_reset` and both error flags are 0. `q_state` only takes the values 0 (open), 1 (waiting on earlier packets) and 2 (waiting on dependencies).
- R2: A wakeup that sees `dep_rd_pending` high does not evaluate the packet. It sets `q_state` to 2, issues nothing, and rearms the wakeup after the processing delay.
- R3: A wakeup that sees `pkt_barrier` high while `inflight_cnt` is nonzero sets `bar_flag` and `q_state` to 1, and issues nothing. With `inflight_cnt` zero, the barrier flag has no blocking effect.
- R4: Packet types 0 (vendor) and 1 (kernel) are issued. `disp_valid` rises with `disp_type` equal to the packet type, `disp_idx_inc` pulses for one cycle, and `q_state` becomes 0.
- R5: Packet type 2 (dependency barrier) retires at once when every bit of `dep_done` is 1. It pulses `disp_idx_inc` and `dep_reset`, sets `q_state` to 0, and raises no `disp_valid`. Otherwise `q_state` becomes 2 and the wakeup is rearmed.
- R6: A wakeup request is evaluated `PROC_DLY` cycles after the edge that accepts it, so an issue shows on the outputs `PROC_DLY`+1 cycles after a `doorbell` is sampled. A request that arrives while a wakeup is pending is ignored.
- R7: A wakeup that occurs while `bar_flag` is set does nothing: no issue, no state change and no rearm.
- R8: Every issue, retirement or blocked outcome rearms the wakeup with `PROC_DLY`, so back-to-back issues from a full ring are `PROC_DLY` cycles apart.
- R9: A completion with `cmpl_valid` and `cmpl_last` high while `bar_flag` is set clears the flag, sets `q_state` to 0, and requests a wakeup with delay 1. If `pkt_valid` is low at that moment, the sticky `err_no_pending` is set. A completion without `cmpl_last` leaves the flag set.
- R10: Packet type 3 sets the sticky `err_unknown`, issues nothing, and does not rearm the wakeup.
- R11: While `disp_valid` is high and `disp_ready` is low, `disp_valid` and `disp_type` hold, and no wakeup is evaluated.
- R12: A wakeup that finds `pkt_valid` low does nothing and does not rearm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| doorbell | input | 1 | Request a wakeup after the processing delay |
| pkt_valid | input | 1 | A packet sits at the dispatch position |
| pkt_type | input | 2 | Packet type: 0 vendor, 1 kernel, 2 dependency barrier, 3 reserved |
| pkt_barrier | input | 1 | Packet must wait for all earlier packets |
| inflight_cnt | input | CNT_W | Packets dispatched but not yet completed |
| dep_rd_pending | input | 1 | Dependency status not yet fetched |
| dep_done | input | NSIG | Per-signal satisfied flags (unused slots tied 1) |
| cmpl_valid | input | 1 | A packet completion event |
| cmpl_last | input | 1 | The completion drains the last earlier packet |
| disp_ready | input | 1 | Executor accepts the issued packet |
| disp_valid | output | 1 | Issued packet waiting for acceptance |
| disp_type | output | 2 | Type of the issued packet |
| disp_idx_inc | output | 1 | One-cycle pulse: advance the dispatch position |
| dep_reset | output | 1 | One-cycle pulse: clear dependency state |
| q_state | output | 2 | 0 open, 1 waiting on earlier packets, 2 waiting on dependencies |
| bar_flag | output | 1 | Queue held by a packet's barrier flag |
| err_unknown | output | 1 | Sticky: reserved packet type seen |
| err_no_pending | output | 1 | Sticky: barrier released with no packet pending |

## Verification
The issue path is driven with vendor and kernel packets to confirm that the issued type is passed through. It is also run with a packet left waiting, which shows that consecutive wakeups are exactly one processing delay apart. A second doorbell sent while a wakeup is pending shows whether the timer restarts or is left alone. The barrier-flag case runs with a nonzero in-flight count and then with a completion that is not the last one; together they separate the empty wakeup, the sleep and the one-cycle release. Dependency-fetch, partially satisfied barrier, reserved-type and stalled-executor patterns each show that a held queue issues nothing until its cause clears.

// File: rtl/pqd_pkg.sv
package pqd_pkg;

  typedef enum logic [1:0] {
    QS_OPEN       = 2'd0,
    QS_WAIT_PRIOR = 2'd1,
    QS_WAIT_DEPS  = 2'd2
  } qstate_e;

  typedef enum logic [1:0] {
    PK_VENDOR      = 2'd0,
    PK_KERNEL      = 2'd1,
    PK_AND_BARRIER = 2'd2,
    PK_RSVD        = 2'd3
  } pkind_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_SKIP,
    ACT_WAIT_DEPS,
    ACT_WAIT_PRIOR,
    ACT_ISSUE,
    ACT_RETIRE,
    ACT_BAD
  } act_e;

endpackage

// File: rtl/pqd_dep_gate.sv
module pqd_dep_gate #(
  parameter int NSIG = 5
) (
  input  logic [NSIG-1:0] done,
  output logic            all_done
);
  always_comb begin
    all_done = 1'b1;
    for (int i = 0; i < NSIG; i++) begin
      all_done = all_done & done[i];
    end
  end
endmodule

// File: rtl/pqd_wake_timer.sv
module pqd_wake_timer #(
  parameter int MAX_DLY = 4,
  localparam int TW = $clog2(MAX_DLY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [TW-1:0] req_dly,
  input  logic          hold,
  output logic          fire
);
  logic          armed_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] load_val;

  assign load_val = req_dly - TW'(1);
  assign fire     = armed_q && (cnt_q == '0) && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fire) begin
      armed_q <= req;
      if (req) cnt_q <= load_val;
    end else if (!armed_q) begin
      if (req) begin
        armed_q <= 1'b1;
        cnt_q   <= load_val;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end
endmodule

// File: rtl/pqd_decider.sv
module pqd_decider
  import pqd_pkg::*;
(
  input  logic       pkt_valid,
  input  logic       held,
  input  logic       dep_rd_pending,
  input  logic       pkt_barrier,
  input  logic       earlier_open,
  input  logic [1:0] pkt_type,
  input  logic       deps_ok,
  output act_e       act
);
  always_comb begin
    act = ACT_IDLE;
    if (!pkt_valid) begin
      act = ACT_IDLE;
    end else if (held) begin
      act = ACT_SKIP;
    end else if (dep_rd_pending) begin
      act = ACT_WAIT_DEPS;
    end else if (pkt_barrier && earlier_open) begin
      act = ACT_WAIT_PRIOR;
    end else begin
      case (pkind_e'(pkt_type))
        PK_VENDOR, PK_KERNEL: act = ACT_ISSUE;
        PK_AND_BARRIER:       act = deps_ok ? ACT_RETIRE : ACT_WAIT_DEPS;
        default:              act = ACT_BAD;
      endcase
    end
  end
endmodule

// File: rtl/pq_barrier_dispatch.sv
module pq_barrier_dispatch
  import pqd_pkg::*;
#(
  parameter int PROC_DLY = 4,
  parameter int CNT_W    = 8,
  parameter int NSIG     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             doorbell,
  input  logic             pkt_valid,
  input  logic [1:0]       pkt_type,
  input  logic             pkt_barrier,
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic             dep_rd_pending,
  input  logic [NSIG-1:0]  dep_done,
  input  logic             cmpl_valid,
  input  logic             cmpl_last,
  input  logic             disp_ready,
  output logic             disp_valid,
  output logic [1:0]       disp_type,
  output logic             disp_idx_inc,
  output logic             dep_reset,
  output logic [1:0]       q_state,
  output logic             bar_flag,
  output logic             err_unknown,
  output logic             err_no_pending
);
  localparam int TW = $clog2(PROC_DLY + 1);
  localparam logic [TW-1:0] DLY_FULL = TW'(PROC_DLY);
  localparam logic [TW-1:0] DLY_ONE  = TW'(1);

  logic       fire, hold, deps_ok, release_now, rearm, wake_req;
  logic [TW-1:0] wake_dly;
  act_e       act;

  logic       valid_q, inc_q, drst_q, flag_q, eunk_q, enp_q;
  logic [1:0] type_q;
  qstate_e    state_q;

  assign hold        = valid_q && !disp_ready;
  assign release_now = flag_q && cmpl_valid && cmpl_last;
  assign rearm       = fire && (act == ACT_ISSUE || act == ACT_RETIRE ||
                                act == ACT_WAIT_DEPS || act == ACT_WAIT_PRIOR);
  assign wake_req    = rearm || doorbell || release_now;
  assign wake_dly    = (rearm || doorbell) ? DLY_FULL : DLY_ONE;

  pqd_dep_gate #(.NSIG(NSIG)) u_gate (
    .done     (dep_done),
    .all_done (deps_ok)
  );

  pqd_decider u_dec (
    .pkt_valid      (pkt_valid),
    .held           (flag_q),
    .dep_rd_pending (dep_rd_pending),
    .pkt_barrier    (pkt_barrier),
    .earlier_open   (|inflight_cnt),
    .pkt_type       (pkt_type),
    .deps_ok        (deps_ok),
    .act            (act)
  );

  pqd_wake_timer #(.MAX_DLY(PROC_DLY)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (wake_req),
    .req_dly (wake_dly),
    .hold    (hold),
    .fire    (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      type_q  <= 2'd0;
      inc_q   <= 1'b0;
      drst_q  <= 1'b0;
      flag_q  <= 1'b0;
      eunk_q  <= 1'b0;
      enp_q   <= 1'b0;
      state_q <= QS_OPEN;
    end else begin
      inc_q  <= 1'b0;
      drst_q <= 1'b0;
      if (valid_q && disp_ready) valid_q <= 1'b0;
      if (fire) begin
        case (act)
          ACT_ISSUE: begin
            valid_q <= 1'b1;
            type_q  <= pkt_type;
            inc_q   <= 1'b1;
            state_q <= QS_OPEN;
          end
          ACT_RETIRE: begin
            inc_q   <= 1'b1;
            drst_q  <= 1'b1;
            state_q <= QS_OPEN;
          end
          ACT_WAIT_DEPS:  state_q <= QS_WAIT_DEPS;
          ACT_WAIT_PRIOR: begin
            state_q <= QS_WAIT_PRIOR;
            flag_q  <= 1'b1;
          end
          ACT_BAD: eunk_q <= 1'b1;
          default: ;
        endcase
      end
      if (release_now) begin
        flag_q  <= 1'b0;
        state_q <= QS_OPEN;
        if (!pkt_valid) enp_q <= 1'b1;
      end
    end
  end

  assign disp_valid     = valid_q;
  assign disp_type      = type_q;
  assign disp_idx_inc   = inc_q;
  assign dep_reset      = drst_q;
  assign q_state        = state_q;
  assign bar_flag       = flag_q;
  assign err_unknown    = eunk_q;
  assign err_no_pending = enp_q;
endmodule

// File: rtl/pq_barrier_dispatch_chk.sv
module pq_barrier_dispatch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       disp_ready,
  input logic       disp_valid,
  input logic [1:0] disp_type,
  input logic       disp_idx_inc,
  input logic       dep_reset,
  input logic [1:0] q_state,
  input logic       bar_flag,
  input logic       err_unknown
);
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    q_state != 2'd3);

  p_bit_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bar_flag) |-> (q_state == 2'd1) && !disp_idx_inc);

  p_issue_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_idx_inc |-> q_state == 2'd0);

  p_retire_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dep_reset |-> disp_idx_inc && !disp_valid);

  p_flag_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bar_flag |-> !disp_idx_inc);

  p_clear_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bar_flag) |-> q_state == 2'd0);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown |=> err_unknown);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_type) && !disp_idx_inc);
endmodule

bind pq_barrier_dispatch pq_barrier_dispatch_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .disp_ready   (disp_ready),
  .disp_valid   (disp_valid),
  .disp_type    (disp_type),
  .disp_idx_inc (disp_idx_inc),
  .dep_reset    (dep_reset),
  .q_state      (q_state),
  .bar_flag     (bar_flag),
  .err_unknown  (err_unknown)
);

// File: tb/pq_barrier_dispatch_bench.sv
`timescale 1ns/1ps
module pq_barrier_dispatch_bench;
  localparam int D     = 4;
  localparam int CNT_W = 8;
  localparam int NSIG  = 5;

  logic clk = 1'b0;
  logic rst_n, doorbell, pkt_valid, pkt_barrier, dep_rd_pending;
  logic cmpl_valid, cmpl_last, disp_ready;
  logic [1:0] pkt_type;
  logic [CNT_W-1:0] inflight_cnt;
  logic [NSIG-1:0] dep_done;
  logic disp_valid, disp_idx_inc, dep_reset, bar_flag, err_unknown, err_no_pending;
  logic [1:0] disp_type, q_state;

  int n_chk = 0, n_bad = 0;
  int n_inc = 0, n_drst = 0, n_hs = 0;

  always #2 clk = ~clk;

  pq_barrier_dispatch #(.PROC_DLY(D), .CNT_W(CNT_W), .NSIG(NSIG)) u_pq_barrier_dispatch (
    .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .pkt_valid(pkt_valid),
    .pkt_type(pkt_type), .pkt_barrier(pkt_barrier), .inflight_cnt(inflight_cnt),
    .dep_rd_pending(dep_rd_pending), .dep_done(dep_done), .cmpl_valid(cmpl_valid),
    .cmpl_last(cmpl_last), .disp_ready(disp_ready), .disp_valid(disp_valid),
    .disp_type(disp_type), .disp_idx_inc(disp_idx_inc), .dep_reset(dep_reset),
    .q_state(q_state), .bar_flag(bar_flag), .err_unknown(err_unknown),
    .err_no_pending(err_no_pending)
  );

  always @(posedge clk) begin
    if (disp_idx_inc) n_inc++;
    if (dep_reset) n_drst++;
    if (disp_valid && disp_ready) n_hs++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ring_bell();
    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
  endtask

  task automatic wait_inc(input int k0, output int k);
    k = k0;
    while (!disp_idx_inc && k < 60) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic drain();
    pkt_valid = 1'b0;
    repeat (3 * D + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 q_state", q_state, 0);
    chk("R1 flags", {bar_flag, disp_valid, disp_idx_inc, dep_reset, err_unknown, err_no_pending}, 0);
  endtask

  task automatic t_vendor();
    int k;
    pkt_type = 2'd0; pkt_valid = 1'b1;
    ring_bell();
    wait_inc(1, k);
    chk("R6 issue latency", k, D + 1);
    chk("R4 vendor valid", disp_valid, 1);
    chk("R4 vendor type", disp_type, 0);
    drain();
  endtask

  task automatic t_kernel_spacing();
    int k, base;
    base = n_inc;
    pkt_type = 2'd1; pkt_valid = 1'b1;
    ring_bell();
    wait_inc(1, k);
    chk("R4 kernel type", disp_type, 1);
    chk("R4 state open", q_state, 0);
    @(negedge clk);
    wait_inc(1, k);
    chk("R8 issue spacing", k, D);
    drain();
    chk("R12 no action without packet", n_inc - base, 2);
  endtask

  task automatic t_bell_ignored();
    int k;
    pkt_type = 2'd1; pkt_valid = 1'b1;
    ring_bell();
    @(negedge clk);
    ring_bell();
    wait_inc(3, k);
    chk("R6 second bell ignored", k, D + 1);
    drain();
  endtask

  task automatic t_dep_pending();
    int k, base;
    base = n_inc;
    pkt_type = 2'd1; pkt_valid = 1'b1; dep_rd_pending = 1'b1;
    ring_bell();
    repeat (D) @(negedge clk);
    chk("R2 state deps", q_state, 2);
    chk("R2 nothing issued", n_inc - base, 0);
    dep_rd_pending = 1'b0;
    wait_inc(0, k);
    chk("R2 retry after delay", k, D);
    drain();
  endtask

  task automatic t_and_barrier();
    int k, hs0, dr0;
    hs0 = n_hs; dr0 = n_drst;
    pkt_type = 2'd2; pkt_valid = 1'b1; dep_done = 5'b10111;
    ring_bell();
    repeat (D) @(negedge clk);
    chk("R5 unsatisfied waits", q_state, 2);
    dep_done = '1;
    wait_inc(0, k);
    chk("R5 retire after rearm", k, D);
    chk("R5 dep_reset pulse", dep_reset, 1);
    chk("R5 not issued", disp_valid, 0);
    drain();
    chk("R5 no handshake", n_hs - hs0, 0);
    chk("R5 one reset", n_drst - dr0, 1);
  endtask

  task automatic t_barrier_bit();
    int k, base;
    base = n_inc;
    pkt_type = 2'd1; pkt_valid = 1'b1; pkt_barrier = 1'b1; inflight_cnt = 8'd2;
    ring_bell();
    repeat (D) @(negedge clk);
    chk("R3 flag set", bar_flag, 1);
    chk("R3 state prior", q_state, 1);
    repeat (2 * D) @(negedge clk);
    chk("R7 empty wakeup", n_inc - base, 0);
    chk("R7 state kept", q_state, 1);
    cmpl_valid = 1'b1; cmpl_last = 1'b0; inflight_cnt = 8'd1;
    @(negedge clk);
    cmpl_valid = 1'b0;
    repeat (2 * D) @(negedge clk);
    chk("R9 non-last keeps flag", bar_flag, 1);
    inflight_cnt = 8'd0; cmpl_valid = 1'b1; cmpl_last = 1'b1;
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_last = 1'b0;
    chk("R9 flag cleared", bar_flag, 0);
    chk("R9 state open", q_state, 0);
    wait_inc(1, k);
    chk("R9 one-cycle release", k, 2);
    chk("R3 issued with none in flight", disp_valid, 1);
    chk("R9 no error", err_no_pending, 0);
    pkt_barrier = 1'b0;
    drain();
  endtask

  task automatic t_backpressure();
    int k, base, hs0;
    base = n_inc; hs0 = n_hs;
    disp_ready = 1'b0; pkt_type = 2'd0; pkt_valid = 1'b1;
    ring_bell();
    wait_inc(1, k);
    chk("R11 first issue", k, D + 1);
    repeat (2 * D) @(negedge clk);
    chk("R11 valid held", disp_valid, 1);
    chk("R11 type held", disp_type, 0);
    chk("R11 no new wakeup", n_inc - base, 1);
    disp_ready = 1'b1; pkt_valid = 1'b0;
    @(negedge clk);
    chk("R11 accepted", disp_valid, 0);
    chk("R11 one handshake", n_hs - hs0, 1);
    drain();
  endtask

  task automatic t_unknown();
    int base;
    base = n_inc;
    pkt_type = 2'd3; pkt_valid = 1'b1;
    ring_bell();
    repeat (D + 1) @(negedge clk);
    chk("R10 error flag", err_unknown, 1);
    pkt_type = 2'd1;
    repeat (3 * D) @(negedge clk);
    chk("R10 no rearm", n_inc - base, 0);
    chk("R10 sticky", err_unknown, 1);
    drain();
  endtask

  task automatic t_no_pending();
    pkt_type = 2'd1; pkt_valid = 1'b1; pkt_barrier = 1'b1; inflight_cnt = 8'd1;
    ring_bell();
    repeat (D) @(negedge clk);
    chk("R3 flag for release test", bar_flag, 1);
    pkt_valid = 1'b0; inflight_cnt = 8'd0; cmpl_valid = 1'b1; cmpl_last = 1'b1;
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_last = 1'b0; pkt_barrier = 1'b0;
    chk("R9 empty release error", err_no_pending, 1);
    chk("R9 flag cleared", bar_flag, 0);
    drain();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; doorbell = 1'b0; pkt_valid = 1'b0; pkt_type = 2'd0;
    pkt_barrier = 1'b0; inflight_cnt = '0; dep_rd_pending = 1'b0;
    dep_done = '1; cmpl_valid = 1'b0; cmpl_last = 1'b0; disp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vendor();
    t_kernel_spacing();
    t_bell_ignored();
    t_dep_pending();
    t_and_barrier();
    t_barrier_bit();
    t_backpressure();
    t_unknown();
    t_no_pending();
    summary();
    $finish;
  end
endmodule